// File: doc/BRIEF.md
# Monitor Setup Readback Serializer

This block keeps the setup of a four-channel window monitor and streams it back to a host as a series of bytes. The setup consists of a 3-bit delay code, an interrupt-enable bit, a differential-pairing flag, a 2-bit scan-limit code, and for every channel a 12-bit lower and a 12-bit upper trip threshold. The setup fields are written through a parallel configuration load. The thresholds are written through a separate per-channel load port. A bus protocol layer sits outside this block and asks for bytes through a simple handshake: `rd_start` opens a readback, `rd_next` moves to the following byte, and `rd_stop` abandons the transfer.

The first byte is a header. Its top nibble always reads as ones, followed by the delay code and the interrupt-enable bit. Each channel that the current mode includes then adds three bytes, which hold the lower threshold followed by the upper threshold. Channels that the pairing mode or the scan limit leaves out are skipped as whole groups. After the last included channel, the block returns 0xFF and raises a done flag for as long as the host keeps asking.

The sequencer has four states. ST_IDLE drives nothing valid. ST_HDR presents the header. ST_CHAN presents one byte of one channel group. ST_DONE presents the filler byte. The transitions are as follows:
- start: any state goes to ST_HDR.
- stop: any state goes to ST_IDLE, and stop wins over start.
- first: `rd_next` in ST_HDR goes to ST_CHAN on channel 0, byte 0.
- advance: `rd_next` in ST_CHAN moves to the next byte.
- hop: after the third byte, `rd_next` moves to the next included channel.
- finish: if no included channel is left, `rd_next` goes to ST_DONE.
- hold: ST_DONE stays in ST_DONE.

Top module: `mon_readback_ser`

## Requirements
- R1: After reset, `rd_valid`, `rd_done` and `rd_byte` are all 0. The stored delay code, interrupt enable, differential flag, scan limit and all thresholds are also 0.
- R2: One cycle after `rd_start` (with `rd_stop` low), `rd_valid` is 1 and `rd_byte` equals {4'b1111, delay[2:0], int_en}, with bit 7 sent first.
- R3: An included channel produces three bytes in this order: lo[11:4], then {lo[3:0], hi[11:8]}, then hi[7:0]. Each byte appears one cycle after the `rd_next` that requests it.
- R4: Channel 0 thresholds are always sent, directly after the header.
- R5: Channel 1 is skipped when the differential flag is 1 or the scan limit is 0.
- R6: Channel 2 is skipped when the scan limit is below 2.
- R7: Channel 3 is skipped when the differential flag is 1 or the scan limit is below 3.
- R8: A `rd_next` after the last byte of the last included channel gives `rd_byte` = 0xFF with `rd_done` = 1, and further requests repeat this. `rd_done` is 0 in all other states.
- R9: One cycle after `rd_stop`, `rd_valid` and `rd_done` are 0 and `rd_byte` is 0. The next `rd_start` begins again at the header.
- R10: A `rd_start` during an active readback restarts the sequence at the header byte.
- R11: A `rd_next` while idle has no effect: the outputs stay idle and a later start still begins at the header.
- R12: `thr_ld` stores `thr_lo`/`thr_hi` for channel `thr_ch`, and `cfg_ld` stores the delay code, interrupt enable, differential flag and scan limit. Both loads take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ld | input | 1 | Store the setup fields |
| cfg_dly | input | 3 | Delay code |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_diff | input | 1 | Differential pairing flag |
| cfg_scan | input | 2 | Scan-limit code (highest channel) |
| thr_ld | input | 1 | Store thresholds for one channel |
| thr_ch | input | 2 | Channel being written |
| thr_lo | input | 12 | Lower threshold |
| thr_hi | input | 12 | Upper threshold |
| rd_start | input | 1 | Begin a readback at the header |
| rd_next | input | 1 | Request the following byte |
| rd_stop | input | 1 | Abandon the readback |
| rd_byte | output | 8 | Current byte |
| rd_valid | output | 1 | A readback is active |
| rd_done | output | 1 | All included channels have been sent |

## Verification
Every handshake input acts at the clock edge that samples it, and the outputs are decoded from the registered state. A start, next-byte or stop request is therefore visible exactly one edge later, and a configuration or threshold load is visible to any byte presented after the edge that stores it. The bench drives all inputs on the falling edge and compares outputs on the following falling edge, so each comparison falls in the cycle that follows the single edge the request needs. Expected byte streams are built by bench functions from the stored setup, using the skip rules written out separately for each channel.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_CHAN = 2'd2,
        ST_DONE = 2'd3
    } rb_state_t;

    localparam logic [3:0] HDR_ONES  = 4'hF;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/mrb_thr_store.sv
module mrb_thr_store #(
    parameter int NCH = 4,
    parameter int TW  = 12,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CW-1:0]     ld_ch,
    input  logic [TW-1:0]     ld_lo,
    input  logic [TW-1:0]     ld_hi,
    output logic [NCH*TW-1:0] lo_flat,
    output logic [NCH*TW-1:0] hi_flat
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [TW-1:0] lo_q;
        logic [TW-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (ld_en && (ld_ch == CW'(g))) begin
                lo_q <= ld_lo;
                hi_q <= ld_hi;
            end
        end

        assign lo_flat[g*TW +: TW] = lo_q;
        assign hi_flat[g*TW +: TW] = hi_q;

        // R12: a load aimed at this channel lands at the next edge
        assert_thr_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && ld_ch == CW'(g)) |=> (lo_q == $past(ld_lo) && hi_q == $past(ld_hi)));
    end

endmodule

// File: rtl/mrb_chan_plan.sv
module mrb_chan_plan #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           diff,
    input  logic [CW-1:0]  scan,
    input  logic [CW-1:0]  cur_ch,
    output logic [NCH-1:0] incl,
    output logic           has_next,
    output logic [CW-1:0]  next_ch
);

    // Channel i is kept when it lies within the scan limit and is not the
    // odd partner of a differential pair.
    for (genvar g = 0; g < NCH; g++) begin : g_incl
        if (g == 0) begin : g_first
            assign incl[g] = 1'b1;
        end else if (g % 2 == 1) begin : g_odd
            assign incl[g] = !diff && (int'(scan) >= g);
        end else begin : g_even
            assign incl[g] = (int'(scan) >= g);
        end
    end

    always_comb begin
        has_next = 1'b0;
        next_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (incl[i] && (i > int'(cur_ch))) begin
                has_next = 1'b1;
                next_ch  = CW'(i);
            end
        end
    end

    // R4: channel 0 is never dropped
    assert_ch0_kept_R4: assert final (incl[0]);

endmodule

// File: rtl/mrb_seq.sv
module mrb_seq
    import mrb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 12,
    localparam int CW    = $clog2(NCH),
    localparam int GW    = 2 * TW,
    localparam int NBYTE = GW / 8,
    localparam int IW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           next,
    input  logic           stop,
    input  logic [NCH-1:0] incl,
    input  logic           has_next,
    input  logic [CW-1:0]  next_ch,
    input  logic [7:0]     hdr,
    input  logic [GW-1:0]  grp,
    output logic [CW-1:0]  cur_ch,
    output logic [7:0]     byte_o,
    output logic           valid_o,
    output logic           done_o
);

    rb_state_t     st_q, st_d;
    logic [CW-1:0] ch_q, ch_d;
    logic [IW-1:0] ix_q, ix_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            ch_q <= '0;
            ix_q <= '0;
        end else begin
            st_q <= st_d;
            ch_q <= ch_d;
            ix_q <= ix_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        ch_d = ch_q;
        ix_d = ix_q;
        if (stop) begin
            st_d = ST_IDLE;
            ch_d = '0;
            ix_d = '0;
        end else if (start) begin
            st_d = ST_HDR;
            ch_d = '0;
            ix_d = '0;
        end else if (next) begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_HDR: begin
                    st_d = ST_CHAN;
                    ch_d = '0;
                    ix_d = '0;
                end
                ST_CHAN: begin
                    if (ix_q != IW'(NBYTE - 1)) begin
                        ix_d = ix_q + 1'b1;
                    end else if (has_next) begin
                        ch_d = next_ch;
                        ix_d = '0;
                    end else begin
                        st_d = ST_DONE;
                    end
                end
                ST_DONE: st_d = ST_DONE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        byte_o  = 8'h00;
        valid_o = 1'b0;
        done_o  = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_HDR: begin
                valid_o = 1'b1;
                byte_o  = hdr;
            end
            ST_CHAN: begin
                valid_o = 1'b1;
                for (int b = 0; b < NBYTE; b++) begin
                    if (ix_q == IW'(b)) byte_o = grp[(NBYTE-1-b)*8 +: 8];
                end
            end
            ST_DONE: begin
                valid_o = 1'b1;
                done_o  = 1'b1;
                byte_o  = FILL_BYTE;
            end
            default: ;
        endcase
    end

    assign cur_ch = ch_q;

    // R5/R6/R7: the sequencer only ever sits on a channel the plan includes
    assert_chan_included_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHAN) |-> incl[ch_q]);

    // R3: within a group a request keeps the channel and steps the byte
    assert_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHAN && next && !stop && !start && ix_q != IW'(NBYTE - 1))
        |=> (st_q == ST_CHAN && ch_q == $past(ch_q) && ix_q == $past(ix_q) + 1'b1));

    // R3: the byte index never passes the group length
    assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHAN) |-> (int'(ix_q) < NBYTE));

    // R11: a request while idle leaves the sequencer idle
    assert_idle_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/mon_readback_ser.sv
module mon_readback_ser
    import mrb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 12,
    parameter int DW  = 3,
    localparam int CW = $clog2(NCH),
    localparam int GW = 2 * TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ld,
    input  logic [DW-1:0] cfg_dly,
    input  logic          cfg_ie,
    input  logic          cfg_diff,
    input  logic [CW-1:0] cfg_scan,
    input  logic          thr_ld,
    input  logic [CW-1:0] thr_ch,
    input  logic [TW-1:0] thr_lo,
    input  logic [TW-1:0] thr_hi,
    input  logic          rd_start,
    input  logic          rd_next,
    input  logic          rd_stop,
    output logic [7:0]    rd_byte,
    output logic          rd_valid,
    output logic          rd_done
);

    logic [DW-1:0]     dly_q;
    logic              ie_q;
    logic              diff_q;
    logic [CW-1:0]     scan_q;
    logic [NCH*TW-1:0] lo_flat;
    logic [NCH*TW-1:0] hi_flat;
    logic [NCH-1:0]    incl;
    logic              has_next;
    logic [CW-1:0]     next_ch;
    logic [CW-1:0]     cur_ch;
    logic [7:0]        hdr;
    logic [GW-1:0]     grp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= '0;
            ie_q   <= 1'b0;
            diff_q <= 1'b0;
            scan_q <= '0;
        end else if (cfg_ld) begin
            dly_q  <= cfg_dly;
            ie_q   <= cfg_ie;
            diff_q <= cfg_diff;
            scan_q <= cfg_scan;
        end
    end

    assign hdr = {HDR_ONES, dly_q, ie_q};
    assign grp = {lo_flat[cur_ch*TW +: TW], hi_flat[cur_ch*TW +: TW]};

    mrb_thr_store #(.NCH(NCH), .TW(TW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (thr_ld),
        .ld_ch   (thr_ch),
        .ld_lo   (thr_lo),
        .ld_hi   (thr_hi),
        .lo_flat (lo_flat),
        .hi_flat (hi_flat)
    );

    mrb_chan_plan #(.NCH(NCH)) u_plan (
        .diff     (diff_q),
        .scan     (scan_q),
        .cur_ch   (cur_ch),
        .incl     (incl),
        .has_next (has_next),
        .next_ch  (next_ch)
    );

    mrb_seq #(.NCH(NCH), .TW(TW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_start),
        .next     (rd_next),
        .stop     (rd_stop),
        .incl     (incl),
        .has_next (has_next),
        .next_ch  (next_ch),
        .hdr      (hdr),
        .grp      (grp),
        .cur_ch   (cur_ch),
        .byte_o   (rd_byte),
        .valid_o  (rd_valid),
        .done_o   (rd_done)
    );

    // R2: a start request presents the header with its top nibble all ones
    assert_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !rd_stop) |=> (rd_valid && !rd_done && rd_byte[7:4] == 4'hF));

    // R9: a stop request leaves the outputs idle
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stop |=> (!rd_valid && !rd_done && rd_byte == 8'h00));

    // R8: the done flag comes with the filler byte
    assert_done_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rd_valid && rd_byte == 8'hFF));

    // R8: once done, further requests keep it done
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_stop && !rd_start) |=> rd_done);

    // R10: a start while active goes back to the header
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_start && !rd_stop) |=> (rd_byte == {4'hF, $past(dly_q), $past(ie_q)}
                                                || $past(cfg_ld)));

endmodule

// File: tb/sim_mon_readback_ser.sv
`timescale 1ns/1ps
module sim_mon_readback_ser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ld = 1'b0;
    logic [2:0]  cfg_dly = '0;
    logic        cfg_ie = 1'b0;
    logic        cfg_diff = 1'b0;
    logic [1:0]  cfg_scan = '0;
    logic        thr_ld = 1'b0;
    logic [1:0]  thr_ch = '0;
    logic [11:0] thr_lo = '0;
    logic [11:0] thr_hi = '0;
    logic        rd_start = 1'b0;
    logic        rd_next = 1'b0;
    logic        rd_stop = 1'b0;
    logic [7:0]  rd_byte;
    logic        rd_valid;
    logic        rd_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [2:0]  m_dly;
    logic        m_ie;
    logic        m_diff;
    logic [1:0]  m_scan;
    logic [11:0] m_lo [4];
    logic [11:0] m_hi [4];

    always #5 clk = ~clk;

    mon_readback_ser u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_ld(cfg_ld), .cfg_dly(cfg_dly), .cfg_ie(cfg_ie),
        .cfg_diff(cfg_diff), .cfg_scan(cfg_scan),
        .thr_ld(thr_ld), .thr_ch(thr_ch), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .rd_start(rd_start), .rd_next(rd_next), .rd_stop(rd_stop),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .rd_done(rd_done)
    );

    // outputs packed as {valid, done, byte}
    function automatic logic [9:0] obs();
        return {rd_valid, rd_done, rd_byte};
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // skip rules stated one channel at a time
    function automatic bit exp_incl(input int ch);
        case (ch)
            0: return 1'b1;
            1: return !(m_diff || m_scan < 2'd1);
            2: return !(m_scan < 2'd2);
            default: return !(m_diff || m_scan < 2'd3);
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input int ch, input int b);
        case (b)
            0: return m_lo[ch][11:4];
            1: return {m_lo[ch][3:0], m_hi[ch][11:8]};
            default: return m_hi[ch][7:0];
        endcase
    endfunction

    function automatic string ch_req(input int ch);
        case (ch)
            0: return "R3,R4";
            1: return "R3,R5";
            2: return "R3,R6";
            default: return "R3,R7";
        endcase
    endfunction

    task automatic load_cfg(input logic [2:0] d, input logic ie, input logic df, input logic [1:0] sc);
        cfg_dly = d; cfg_ie = ie; cfg_diff = df; cfg_scan = sc; cfg_ld = 1'b1;
        @(negedge clk);
        cfg_ld = 1'b0;
        m_dly = d; m_ie = ie; m_diff = df; m_scan = sc;
    endtask

    task automatic load_thr(input int ch, input logic [11:0] lo, input logic [11:0] hi);
        thr_ch = 2'(ch); thr_lo = lo; thr_hi = hi; thr_ld = 1'b1;
        @(negedge clk);
        thr_ld = 1'b0;
        m_lo[ch] = lo; m_hi[ch] = hi;
    endtask

    task automatic pulse_start();
        rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
    endtask
    task automatic pulse_next();
        rd_next = 1'b1; @(negedge clk); rd_next = 1'b0;
    endtask
    task automatic pulse_stop();
        rd_stop = 1'b1; @(negedge clk); rd_stop = 1'b0;
    endtask

    function automatic logic [9:0] exp_hdr();
        return {2'b10, 4'hF, m_dly, m_ie};
    endfunction

    task automatic full_read();
        pulse_start();
        chk("R2", obs(), exp_hdr());
        for (int ch = 0; ch < 4; ch++) begin
            if (exp_incl(ch)) begin
                for (int b = 0; b < 3; b++) begin
                    pulse_next();
                    chk(ch_req(ch), obs(), {2'b10, exp_byte(ch, b)});
                end
            end
        end
        for (int k = 0; k < 2; k++) begin
            pulse_next();
            chk("R8", obs(), {2'b11, 8'hFF});
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_dly = '0; m_ie = 1'b0; m_diff = 1'b0; m_scan = '0;
        for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", obs(), 10'h000);

        // R1/R12: reset setup is all zero, so the read is header F0 then zero bytes
        full_read();
        pulse_stop();

        // R12 / R3: distinct bit patterns on every channel, every mode combination
        load_thr(0, 12'hABC, 12'h123);
        load_thr(1, 12'h5A5, 12'hA5A);
        load_thr(2, 12'hF0F, 12'h0F0);
        load_thr(3, 12'h876, 12'h321);
        for (int m = 0; m < 8; m++) begin
            load_cfg(3'(m), 1'(m), 1'(m >> 2), 2'(m));
            full_read();
            pulse_stop();
            chk("R9", obs(), 10'h000);
        end

        // constrained random setups and thresholds
        for (int r = 0; r < 24; r++) begin
            for (int c = 0; c < 4; c++) load_thr(c, 12'($urandom), 12'($urandom));
            load_cfg(3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
            full_read();
            if (r % 2 == 0) pulse_stop();
        end

        // R11: next while idle is ignored
        pulse_stop();
        load_cfg(3'd5, 1'b1, 1'b0, 2'd3);
        pulse_next();
        chk("R11", obs(), 10'h000);
        pulse_start();
        chk("R11", obs(), exp_hdr());

        // R9: stop in the middle, then start again from the header
        pulse_next();
        pulse_next();
        pulse_stop();
        chk("R9", obs(), 10'h000);
        pulse_start();
        chk("R9", obs(), exp_hdr());
        pulse_next();
        chk("R9", obs(), {2'b10, exp_byte(0, 0)});

        // R10: start while in a channel group returns to the header
        pulse_next();
        pulse_next();
        pulse_next();
        chk("R10", obs(), {2'b10, exp_byte(1, 0)});
        pulse_start();
        chk("R10", obs(), exp_hdr());
        pulse_next();
        chk("R10", obs(), {2'b10, exp_byte(0, 0)});

        // R10: start while done also returns to the header
        load_cfg(3'd2, 1'b0, 1'b1, 2'd0);
        full_read();
        pulse_start();
        chk("R10", obs(), exp_hdr());

        // R9: stop has priority over a simultaneous start
        rd_start = 1'b1; rd_stop = 1'b1;
        @(negedge clk);
        rd_start = 1'b0; rd_stop = 1'b0;
        chk("R9", obs(), 10'h000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule